// File: doc/BRIEF.md
# MII PHY-Side Signalling Controller

This block sits on the PHY side of a Media Independent Interface and turns nibble-level activity into the interface's control and data signals. It is clocked by a fast system clock and advanced by a nibble strobe, `nib_stb`, which fires once per nibble period. That period is 40 ns at 100 Mb/s and 400 ns at 10 Mb/s, and the strobe runs continuously. The selected speed changes when receive data becomes valid, whether the collision output carries a test pulse, and whether receive clock gating is allowed.

On the transmit side the controller captures a MAC nibble on each strobe while `tx_en` is high and passes it on as a 5-bit symbol. In the normal path the symbol is `{0, txd}`, and `tx_er` asks for an error code group instead of data. In the bypass path `tx_er` becomes bit 4 of a raw code group. On the receive side a framing state machine follows the markers from the receive decoder: preamble start, delimiter seen and last nibble. It produces `rx_dv` and `rxd` from them. Carrier sense and collision are formed from transmit and receive activity. Output-enable signals tell the pads when to float the receive-side outputs and the transmit clock.

The receive machine has three states. `RX_IDLE` moves to `RX_FRAME` on a preamble marker at 100 Mb/s, or to `RX_HUNT` on a preamble marker at 10 Mb/s. `RX_HUNT` moves to `RX_FRAME` on the delimiter marker and back to `RX_IDLE` if activity drops. `RX_FRAME` returns to `RX_IDLE` after the last nibble, or when activity drops. The collision test-pulse machine also has three states. `SQE_IDLE` moves to `SQE_WAIT` when `tx_en` falls at 10 Mb/s with a non-zero length. `SQE_WAIT` moves to `SQE_PULSE` after `SQE_DLY` strobes. `SQE_PULSE` returns to `SQE_IDLE` after `sqe_len` strobes.

Top module: `mii_phy_ctrl`

## Requirements
- R1: On a strobe with `tx_en` high, `tx_sym_vld` becomes 1 and the captured nibble is presented. On a strobe with `tx_en` low, `tx_sym_vld` becomes 0 and `tx_sym` keeps its previous value.
- R2: With bypass off, a strobe with `tx_en` and `tx_er` both high sets `tx_sym_err` to 1 and `tx_sym` to `{1'b0, txd}`. With `tx_er` low, `tx_sym_err` is 0.
- R3: With `bypass_5b` high, a captured strobe gives `tx_sym = {tx_er, txd}`, with `tx_er` as bit 4, and `tx_sym_err` stays 0.
- R4: When `repeater_mode` is low, `crs` is 1 while `tx_en` or `rx_act` is high. When `repeater_mode` is high, only `rx_act` drives `crs`.
- R5: At 100 Mb/s, `rx_dv` rises with the nibble that carries the preamble marker. It stays high through the nibble flagged `rx_last` and falls on the next strobe.
- R6: At 10 Mb/s, `rx_dv` stays low through the preamble and rises with the nibble that carries the delimiter marker.
- R7: `rxd` is 0 whenever `rx_dv` is low. Reset leaves `rx_dv`, `rxd`, `crs`, `col` and `tx_sym_vld` at 0.
- R8: `col` is 1 while `tx_en` and `rx_act` are both high in half duplex. `col` is held at 0 while `full_duplex` is high.
- R9: At 10 Mb/s in half duplex, a strobe that sees `tx_en` low after a strobe that saw it high starts the test pulse. `col` goes high `SQE_DLY` strobes later (default 4) and stays high for `sqe_len` strobes. With `sqe_len` = 0, or at 100 Mb/s, no pulse occurs.
- R10: `rx_oe` is 0 (receive outputs and receive clock floating) exactly when `isolate` is high. `tx_clk_oe` is 0 when `isolate` or `tx_hiz` is high.
- R11: `rxclk_en` is 0 only when `pwr_save` is high, the speed is 100 Mb/s, `rx_act` is low and the receive machine is idle. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nib_stb | input | 1 | One-cycle nibble strobe |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex |
| repeater_mode | input | 1 | Carrier sense from receive only |
| bypass_5b | input | 1 | Raw 5-bit transmit code groups |
| pwr_save | input | 1 | Allow receive clock gating at 100 Mb/s |
| isolate | input | 1 | Float all interface outputs |
| tx_hiz | input | 1 | Float transmit clock only |
| sqe_len | input | 4 | Test pulse length in strobes |
| tx_en | input | 1 | MAC transmit enable |
| tx_er | input | 1 | MAC error request / code-group bit 4 |
| txd | input | 4 | MAC transmit nibble |
| rx_act | input | 1 | Receive path non-idle |
| rx_pre | input | 1 | Nibble is the first preamble nibble |
| rx_sfd | input | 1 | Nibble carries the frame delimiter |
| rx_last | input | 1 | Nibble is the last data nibble |
| rx_nib | input | 4 | Decoded receive nibble |
| tx_sym_vld | output | 1 | Captured transmit symbol valid |
| tx_sym_err | output | 1 | Error code group requested |
| tx_sym | output | 5 | Transmit symbol to coding stage |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Receive data nibble |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / test pulse |
| rxclk_en | output | 1 | Receive clock enable |
| rx_oe | output | 1 | Pad enable for receive-side outputs |
| tx_clk_oe | output | 1 | Pad enable for transmit clock |

## Verification
Symbol capture and receive framing are registered on the strobe cycle, so their results are due on the first clock after the strobe. Carrier sense, collision and the receive clock enable add one more register after the state they depend on. Each collision result is therefore due two clocks after the strobe that changed the state, or one clock after a level input changes. The output-enable pins follow their inputs in the same cycle. Each bench scenario raises the strobe for one clock, lets a second clock pass, and samples on a falling edge. Every result due within two clocks is then settled, and the test-pulse window is checked strobe by strobe against a count of `SQE_DLY` and `sqe_len`.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_HUNT  = 2'd1,
        RX_FRAME = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        SQE_IDLE  = 2'd0,
        SQE_WAIT  = 2'd1,
        SQE_PULSE = 2'd2
    } sqe_state_e;
endpackage

// File: rtl/mii_tx_capture.sv
module mii_tx_capture #(
    parameter int NIB_W = 4,
    localparam int SYM_W = NIB_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_stb,
    input  logic             bypass_5b,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic             sym_vld,
    output logic             sym_err,
    output logic [SYM_W-1:0] sym
);
    logic             msb_d;
    logic             err_d;

    // The MSB is only meaningful in bypass; the error request only outside it.
    always_comb begin
        msb_d = bypass_5b ? tx_er : 1'b0;
        err_d = tx_er & ~bypass_5b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_vld <= 1'b0;
            sym_err <= 1'b0;
            sym     <= '0;
        end else if (nib_stb) begin
            sym_vld <= tx_en;
            if (tx_en) begin
                sym_err <= err_d;
                sym     <= {msb_d, txd};
            end else begin
                sym_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
    import mii_phy_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_stb,
    input  logic             speed_100,
    input  logic             rx_act,
    input  logic             rx_pre,
    input  logic             rx_sfd,
    input  logic             rx_last,
    input  logic [NIB_W-1:0] rx_nib,
    output logic             rx_dv,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_idle
);
    rx_state_e state_q, state_d;
    logic      dv_d;

    // Next-state and next-output logic.
    always_comb begin
        state_d = state_q;
        dv_d    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (rx_pre) begin
                    if (speed_100) begin
                        state_d = RX_FRAME;
                        dv_d    = 1'b1;
                    end else begin
                        state_d = RX_HUNT;
                    end
                end
            end
            RX_HUNT: begin
                if (!rx_act) begin
                    state_d = RX_IDLE;
                end else if (rx_sfd) begin
                    state_d = RX_FRAME;
                    dv_d    = 1'b1;
                end
            end
            RX_FRAME: begin
                if (!rx_act) begin
                    state_d = RX_IDLE;
                end else begin
                    dv_d = 1'b1;
                    if (rx_last) state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= RX_IDLE;
        else if (nib_stb) state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dv <= 1'b0;
            rxd   <= '0;
        end else if (nib_stb) begin
            rx_dv <= dv_d;
            rxd   <= dv_d ? rx_nib : '0;
        end
    end

    assign rx_idle = (state_q == RX_IDLE);
endmodule

// File: rtl/mii_sqe_timer.sv
module mii_sqe_timer
    import mii_phy_pkg::*;
#(
    parameter int SQE_DLY   = 4,
    parameter int SQE_LEN_W = 4,
    localparam int DLY_W = $clog2(SQE_DLY + 1),
    localparam int CNT_W = (DLY_W > SQE_LEN_W) ? DLY_W : SQE_LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nib_stb,
    input  logic                 speed_100,
    input  logic                 tx_en,
    input  logic [SQE_LEN_W-1:0] sqe_len,
    output logic                 sqe_on
);
    sqe_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tx_en_prev;
    logic             fall;

    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SQE_DLY - 1);

    assign fall = tx_en_prev & ~tx_en;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQE_IDLE: begin
                if (fall && !speed_100 && (sqe_len != '0)) begin
                    state_d = SQE_WAIT;
                    cnt_d   = '0;
                end
            end
            SQE_WAIT: begin
                if (cnt_q == DLY_LAST) begin
                    state_d = SQE_PULSE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQE_PULSE: begin
                if (cnt_q == CNT_W'(sqe_len - 1'b1)) begin
                    state_d = SQE_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = SQE_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SQE_IDLE;
            cnt_q      <= '0;
            tx_en_prev <= 1'b0;
        end else if (nib_stb) begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            tx_en_prev <= tx_en;
        end
    end

    // Output decode.
    always_comb begin
        sqe_on = (state_q == SQE_PULSE);
    end
endmodule

// File: rtl/mii_phy_ctrl.sv
module mii_phy_ctrl
    import mii_phy_pkg::*;
#(
    parameter int SQE_DLY   = 4,
    parameter int SQE_LEN_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nib_stb,
    input  logic                 speed_100,
    input  logic                 full_duplex,
    input  logic                 repeater_mode,
    input  logic                 bypass_5b,
    input  logic                 pwr_save,
    input  logic                 isolate,
    input  logic                 tx_hiz,
    input  logic [SQE_LEN_W-1:0] sqe_len,
    input  logic                 tx_en,
    input  logic                 tx_er,
    input  logic [NIB_W-1:0]     txd,
    input  logic                 rx_act,
    input  logic                 rx_pre,
    input  logic                 rx_sfd,
    input  logic                 rx_last,
    input  logic [NIB_W-1:0]     rx_nib,
    output logic                 tx_sym_vld,
    output logic                 tx_sym_err,
    output logic [NIB_W:0]       tx_sym,
    output logic                 rx_dv,
    output logic [NIB_W-1:0]     rxd,
    output logic                 crs,
    output logic                 col,
    output logic                 rxclk_en,
    output logic                 rx_oe,
    output logic                 tx_clk_oe
);
    logic rx_idle;
    logic sqe_on;

    mii_tx_capture #(.NIB_W(NIB_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_stb   (nib_stb),
        .bypass_5b (bypass_5b),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .txd       (txd),
        .sym_vld   (tx_sym_vld),
        .sym_err   (tx_sym_err),
        .sym       (tx_sym)
    );

    mii_rx_framer #(.NIB_W(NIB_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_stb   (nib_stb),
        .speed_100 (speed_100),
        .rx_act    (rx_act),
        .rx_pre    (rx_pre),
        .rx_sfd    (rx_sfd),
        .rx_last   (rx_last),
        .rx_nib    (rx_nib),
        .rx_dv     (rx_dv),
        .rxd       (rxd),
        .rx_idle   (rx_idle)
    );

    mii_sqe_timer #(.SQE_DLY(SQE_DLY), .SQE_LEN_W(SQE_LEN_W)) sqe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_stb   (nib_stb),
        .speed_100 (speed_100),
        .tx_en     (tx_en),
        .sqe_len   (sqe_len),
        .sqe_on    (sqe_on)
    );

    logic crs_d, col_d, rxclk_d;

    always_comb begin
        crs_d   = rx_act | (tx_en & ~repeater_mode);
        col_d   = ~full_duplex & ((tx_en & rx_act) | sqe_on);
        rxclk_d = ~(pwr_save & speed_100 & ~rx_act & rx_idle);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crs      <= 1'b0;
            col      <= 1'b0;
            rxclk_en <= 1'b1;
        end else begin
            crs      <= crs_d;
            col      <= col_d;
            rxclk_en <= rxclk_d;
        end
    end

    assign rx_oe     = ~isolate;
    assign tx_clk_oe = ~(isolate | tx_hiz);
endmodule

// File: rtl/mii_phy_ctrl_chk.sv
module mii_phy_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_stb,
    input logic       speed_100,
    input logic       full_duplex,
    input logic       repeater_mode,
    input logic       bypass_5b,
    input logic       tx_en,
    input logic       tx_er,
    input logic [3:0] txd,
    input logic       rx_act,
    input logic       rx_sfd,
    input logic       tx_sym_vld,
    input logic [4:0] tx_sym,
    input logic       rx_dv,
    input logic [3:0] rxd,
    input logic       crs,
    input logic       col
);
    assert_idle_strobe_clears_vld_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && !tx_en) |=> !tx_sym_vld);

    assert_bypass_code_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && tx_en && bypass_5b) |=> (tx_sym == {$past(tx_er), $past(txd)}));

    assert_repeater_crs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (repeater_mode && !rx_act) |=> !crs);

    assert_dv_rises_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> $past(nib_stb));

    assert_slow_dv_needs_sfd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_dv) && $past(!speed_100)) |-> $past(rx_sfd));

    assert_rxd_zero_when_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |-> (rxd == 4'd0));

    assert_full_duplex_no_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !col);
endmodule

bind mii_phy_ctrl mii_phy_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .nib_stb       (nib_stb),
    .speed_100     (speed_100),
    .full_duplex   (full_duplex),
    .repeater_mode (repeater_mode),
    .bypass_5b     (bypass_5b),
    .tx_en         (tx_en),
    .tx_er         (tx_er),
    .txd           (txd),
    .rx_act        (rx_act),
    .rx_sfd        (rx_sfd),
    .tx_sym_vld    (tx_sym_vld),
    .tx_sym        (tx_sym),
    .rx_dv         (rx_dv),
    .rxd           (rxd),
    .crs           (crs),
    .col           (col)
);

// File: tb/mii_phy_ctrl_tb.sv
module mii_phy_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_stb = 1'b0;
    logic       speed_100 = 1'b1, full_duplex = 1'b0, repeater_mode = 1'b0;
    logic       bypass_5b = 1'b0, pwr_save = 1'b0, isolate = 1'b0, tx_hiz = 1'b0;
    logic [3:0] sqe_len = 4'd0;
    logic       tx_en = 1'b0, tx_er = 1'b0;
    logic [3:0] txd = 4'd0;
    logic       rx_act = 1'b0, rx_pre = 1'b0, rx_sfd = 1'b0, rx_last = 1'b0;
    logic [3:0] rx_nib = 4'd0;
    logic       tx_sym_vld, tx_sym_err, rx_dv, crs, col, rxclk_en, rx_oe, tx_clk_oe;
    logic [4:0] tx_sym;
    logic [3:0] rxd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mii_phy_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nib_stb(nib_stb), .speed_100(speed_100),
        .full_duplex(full_duplex), .repeater_mode(repeater_mode), .bypass_5b(bypass_5b),
        .pwr_save(pwr_save), .isolate(isolate), .tx_hiz(tx_hiz), .sqe_len(sqe_len),
        .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .rx_act(rx_act), .rx_pre(rx_pre),
        .rx_sfd(rx_sfd), .rx_last(rx_last), .rx_nib(rx_nib),
        .tx_sym_vld(tx_sym_vld), .tx_sym_err(tx_sym_err), .tx_sym(tx_sym),
        .rx_dv(rx_dv), .rxd(rxd), .crs(crs), .col(col), .rxclk_en(rxclk_en),
        .rx_oe(rx_oe), .tx_clk_oe(tx_clk_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobe, then one extra clock so two-register results are settled.
    task automatic strobe();
        nib_stb = 1'b1;
        @(negedge clk);
        nib_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 reset rx_dv", rx_dv, 0);
        chk("R7 reset rxd", rxd, 0);
        chk("R7 reset crs", crs, 0);
        chk("R7 reset col", col, 0);
        chk("R7 reset tx_sym_vld", tx_sym_vld, 0);
    endtask

    task automatic t_tx_capture();
        tx_en = 1; txd = 4'hA; strobe();
        chk("R1 vld", tx_sym_vld, 1);
        chk("R1 sym", tx_sym, 5'h0A);
        chk("R2 no err", tx_sym_err, 0);
        tx_en = 0; txd = 4'h5; strobe();
        chk("R1 vld low", tx_sym_vld, 0);
        chk("R1 sym held", tx_sym, 5'h0A);
    endtask

    task automatic t_tx_error();
        tx_en = 1; tx_er = 1; txd = 4'h6; strobe();
        chk("R2 err", tx_sym_err, 1);
        chk("R2 sym", tx_sym, 5'h06);
        tx_er = 0; tx_en = 0; strobe();
    endtask

    task automatic t_bypass();
        bypass_5b = 1; tx_en = 1; tx_er = 1; txd = 4'h3; strobe();
        chk("R3 sym", tx_sym, 5'h13);
        chk("R3 err", tx_sym_err, 0);
        tx_er = 0; txd = 4'hC; strobe();
        chk("R3 sym msb0", tx_sym, 5'h0C);
        tx_en = 0; bypass_5b = 0; strobe();
    endtask

    task automatic t_crs();
        tx_en = 1; strobe();
        chk("R4 crs tx", crs, 1);
        repeater_mode = 1; @(negedge clk);
        chk("R4 crs repeater tx only", crs, 0);
        rx_act = 1; @(negedge clk);
        chk("R4 crs repeater rx", crs, 1);
        rx_act = 0; tx_en = 0; repeater_mode = 0; strobe();
        chk("R4 crs idle", crs, 0);
    endtask

    task automatic t_rx100();
        speed_100 = 1; rx_act = 1; rx_pre = 1; rx_nib = 4'h5; strobe();
        rx_pre = 0;
        chk("R5 dv with preamble", rx_dv, 1);
        chk("R5 rxd", rxd, 5);
        rx_nib = 4'h9; strobe();
        chk("R5 data", rxd, 9);
        rx_nib = 4'hE; rx_last = 1; strobe();
        rx_last = 0;
        chk("R5 last dv", rx_dv, 1);
        chk("R5 last rxd", rxd, 14);
        rx_nib = 4'h7; strobe();
        chk("R5 dv falls", rx_dv, 0);
        chk("R7 rxd zero", rxd, 0);
        rx_act = 0; strobe();
    endtask

    task automatic t_rx10();
        speed_100 = 0; rx_act = 1; rx_pre = 1; rx_nib = 4'h5; strobe();
        rx_pre = 0;
        chk("R6 no dv on preamble", rx_dv, 0);
        chk("R7 rxd zero preamble", rxd, 0);
        strobe();
        chk("R6 no dv before sfd", rx_dv, 0);
        rx_sfd = 1; rx_nib = 4'hD; strobe();
        rx_sfd = 0;
        chk("R6 dv on sfd", rx_dv, 1);
        chk("R6 rxd sfd", rxd, 13);
        rx_last = 1; rx_nib = 4'h2; strobe();
        rx_last = 0; rx_act = 0; strobe();
        chk("R6 dv end", rx_dv, 0);
        speed_100 = 1;
    endtask

    task automatic t_col();
        speed_100 = 1; tx_en = 1; rx_act = 1; strobe();
        chk("R8 col half", col, 1);
        full_duplex = 1; @(negedge clk); @(negedge clk);
        chk("R8 col full duplex", col, 0);
        full_duplex = 0; tx_en = 0; rx_act = 0; strobe(); strobe();
        chk("R8 col idle", col, 0);
    endtask

    task automatic t_sqe();
        speed_100 = 0; sqe_len = 4'd2;
        tx_en = 1; strobe();
        tx_en = 0; strobe();                 // fall seen on this strobe
        for (int i = 1; i < 4; i++) begin
            strobe();
            chk("R9 col during delay", col, 0);
        end
        strobe();
        chk("R9 pulse start", col, 1);
        strobe();
        chk("R9 pulse second", col, 1);
        strobe();
        chk("R9 pulse end", col, 0);
        sqe_len = 4'd0; tx_en = 1; strobe(); tx_en = 0; strobe();
        for (int i = 0; i < 6; i++) begin
            strobe();
            chk("R9 no pulse len0", col, 0);
        end
        speed_100 = 1; sqe_len = 4'd3; tx_en = 1; strobe(); tx_en = 0; strobe();
        for (int i = 0; i < 6; i++) begin
            strobe();
            chk("R9 no pulse 100M", col, 0);
        end
        sqe_len = 4'd0;
    endtask

    task automatic t_isolate();
        chk("R10 rx_oe normal", rx_oe, 1);
        chk("R10 tx_clk_oe normal", tx_clk_oe, 1);
        tx_hiz = 1; #1;
        chk("R10 tx_hiz rx_oe", rx_oe, 1);
        chk("R10 tx_hiz tx_clk_oe", tx_clk_oe, 0);
        tx_hiz = 0; isolate = 1; #1;
        chk("R10 isolate rx_oe", rx_oe, 0);
        chk("R10 isolate tx_clk_oe", tx_clk_oe, 0);
        isolate = 0; @(negedge clk);
    endtask

    task automatic t_rxclk();
        chk("R11 default enabled", rxclk_en, 1);
        pwr_save = 1; speed_100 = 1; @(negedge clk);
        chk("R11 gated idle", rxclk_en, 0);
        rx_act = 1; @(negedge clk);
        chk("R11 active", rxclk_en, 1);
        rx_act = 0; speed_100 = 0; @(negedge clk);
        chk("R11 10M not gated", rxclk_en, 1);
        speed_100 = 1; pwr_save = 0; @(negedge clk);
        chk("R11 off", rxclk_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_capture();
        t_tx_error();
        t_bypass();
        t_crs();
        t_rx100();
        t_rx10();
        t_col();
        t_sqe();
        t_isolate();
        t_rxclk();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule